// File: doc/BRIEF.md
# LED Driver Mode Sequencer with Global Brightness Register

This block sits beside the serial shift register and channel latches of a constant-current LED driver. It watches the output-blank and latch control inputs on every rising clock edge and keeps a short history of them. Two fixed five-step patterns on those inputs move the driver between its normal mode and its special mode. There is no register write for this. In normal mode a latch pulse is passed on as a load strobe for the channel latches. In special mode the same pulse copies the shift-register word into an 8-bit global brightness register.

The brightness code is decoded into a 7-bit gain index and an 8-bit gain fraction of full scale. Code bit 1 selects the range. Code bits 2 to 7 form the step, with bit 2 as its most significant bit. Code bit 0 is reserved. When the block leaves special mode it raises a one-cycle strobe that clears the channel data. The analog current reference and the fault detection are handled elsewhere.

Top module: `led_mode_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the block is in normal mode, the brightness code is 0xFF, and both chan_load_o and chan_clear_o are low.
- R2: If five consecutive sampled (blank_i, strobe_i) pairs are (1,0),(0,0),(1,0),(1,1),(1,0), special_o is high from the cycle after the fifth edge.
- R3: If five consecutive pairs are (1,0),(0,0),(1,0),(1,0),(1,0), special_o is low from the cycle after the fifth edge. chan_clear_o pulses high for exactly that one cycle, and only if the block was in special mode before that edge.
- R4: A sequence that differs from both patterns in any one sample leaves the mode unchanged.
- R5: In normal mode, strobe_i sampled high at an edge makes chan_load_o high for the following cycle, except in the case of R6.
- R6: If strobe_i is sampled high and, together with the three samples before it, matches the first four steps of the entry pattern, neither the channel latches nor the brightness register are loaded.
- R7: In special mode, strobe_i sampled high (outside R6) copies sr_word_i into the brightness code, visible the next cycle. chan_load_o stays low. The code is otherwise held in both modes.
- R8: gain_idx_o equals {code[1], code[2], code[3], code[4], code[5], code[6], code[7]}. Code bit 0 has no effect on it.
- R9: gain_frac_o is 64 + step when code[1] is 0 and 128 + 2*step when code[1] is 1, where step is gain_idx_o[5:0]. It therefore rises whenever gain_idx_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low reset (power-on) |
| blank_i | input | 1 | Output-blank control, high forces channels off |
| strobe_i | input | 1 | Latch control from the host |
| sr_word_i | input | 8 | Parallel word of the serial shift register |
| special_o | output | 1 | High while in special mode |
| bright_o | output | 8 | Global brightness code |
| gain_idx_o | output | 7 | Decoded gain index {range, step} |
| gain_frac_o | output | 8 | Gain as a fraction of full scale, in 1/256 units |
| chan_load_o | output | 1 | One-cycle load strobe for the channel latches |
| chan_clear_o | output | 1 | One-cycle clear strobe for the channel data |

## Verification
The sequencer is driven with the exact entry and exit patterns in both modes. This separates a real mode change from the clear strobe that only a special-to-normal change may produce. Copies of each pattern with one sample changed show that the matcher compares every step and not just a prefix. A lone entry prefix ending in a latch pulse shows the R6 suppression. Long stretches of random blank, latch and word values show how latch pulses are routed in each mode, and sweeps of brightness codes check the gain decode. The reserved bit is toggled by itself to show that it has no effect on the gain.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

   typedef enum logic {
      MODE_NORMAL  = 1'b0,
      MODE_SPECIAL = 1'b1
   } mseq_mode_e;

   // default control patterns, bit SEQ_LEN-1 is the oldest step
   localparam int          SEQ_LEN_DEF      = 5;
   localparam logic [4:0]  ENTER_BLANK_DEF  = 5'b10111;
   localparam logic [4:0]  ENTER_STROBE_DEF = 5'b00010;
   localparam logic [4:0]  EXIT_BLANK_DEF   = 5'b10111;
   localparam logic [4:0]  EXIT_STROBE_DEF  = 5'b00000;

endpackage

// File: rtl/mseq_history.sv
module mseq_history #(
   parameter int               SEQ_LEN      = 5,
   parameter int               PFX_LEN      = 4,
   parameter logic [SEQ_LEN-1:0] ENTER_BLANK  = 5'b10111,
   parameter logic [SEQ_LEN-1:0] ENTER_STROBE = 5'b00010,
   parameter logic [SEQ_LEN-1:0] EXIT_BLANK   = 5'b10111,
   parameter logic [SEQ_LEN-1:0] EXIT_STROBE  = 5'b00000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic blank_i,
   input  logic strobe_i,
   output logic enter_hit_o,
   output logic exit_hit_o,
   output logic pfx_hit_o
);
   localparam int HIST_LEN = SEQ_LEN - 1;
   localparam logic [PFX_LEN-1:0] PFX_BLANK  = PFX_LEN'(ENTER_BLANK  >> (SEQ_LEN - PFX_LEN));
   localparam logic [PFX_LEN-1:0] PFX_STROBE = PFX_LEN'(ENTER_STROBE >> (SEQ_LEN - PFX_LEN));

   generate
      if (SEQ_LEN < 2) begin : g_len_bad
         $error("mseq_history: SEQ_LEN must be at least 2");
      end
      if (PFX_LEN < 1 || PFX_LEN > SEQ_LEN) begin : g_pfx_bad
         $error("mseq_history: PFX_LEN out of range");
      end
      if (ENTER_STROBE == EXIT_STROBE && ENTER_BLANK == EXIT_BLANK) begin : g_same_bad
         $error("mseq_history: entry and exit patterns must differ");
      end
   endgenerate

   logic [HIST_LEN-1:0] blank_h;
   logic [HIST_LEN-1:0] strobe_h;
   logic [SEQ_LEN-1:0]  win_blank;
   logic [SEQ_LEN-1:0]  win_strobe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blank_h  <= '0;
         strobe_h <= '0;
      end else begin
         blank_h  <= win_blank[HIST_LEN-1:0];
         strobe_h <= win_strobe[HIST_LEN-1:0];
      end
   end

   always_comb begin
      win_blank  = {blank_h, blank_i};
      win_strobe = {strobe_h, strobe_i};
      enter_hit_o = (win_blank == ENTER_BLANK) && (win_strobe == ENTER_STROBE);
      exit_hit_o  = (win_blank == EXIT_BLANK)  && (win_strobe == EXIT_STROBE);
      pfx_hit_o   = strobe_i &&
                    (win_blank[PFX_LEN-1:0]  == PFX_BLANK) &&
                    (win_strobe[PFX_LEN-1:0] == PFX_STROBE);
   end

   // R4
   exit_enter_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(enter_hit_o && exit_hit_o));

endmodule

// File: rtl/mseq_mode_ctl.sv
module mseq_mode_ctl
   import mseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strobe_i,
   input  logic       enter_hit_i,
   input  logic       exit_hit_i,
   input  logic       pfx_hit_i,
   output mseq_mode_e mode_o,
   output logic       bright_we_o,
   output logic       chan_load_o,
   output logic       chan_clear_o
);
   mseq_mode_e mode_q;
   mseq_mode_e mode_d;
   logic       load_d;
   logic       clear_d;

   always_comb begin
      mode_d  = mode_q;
      clear_d = 1'b0;
      if (enter_hit_i) begin
         mode_d = MODE_SPECIAL;
      end else if (exit_hit_i) begin
         mode_d  = MODE_NORMAL;
         clear_d = (mode_q == MODE_SPECIAL);
      end
      load_d      = strobe_i && !pfx_hit_i && (mode_q == MODE_NORMAL);
      bright_we_o = strobe_i && !pfx_hit_i && (mode_q == MODE_SPECIAL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q       <= MODE_NORMAL;
         chan_load_o  <= 1'b0;
         chan_clear_o <= 1'b0;
      end else begin
         mode_q       <= mode_d;
         chan_load_o  <= load_d;
         chan_clear_o <= clear_d;
      end
   end

   assign mode_o = mode_q;

   // R2
   enter_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enter_hit_i |=> (mode_q == MODE_SPECIAL));

   // R3
   clear_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_clear_o |-> (mode_q == MODE_NORMAL && $past(mode_q) == MODE_SPECIAL));

   // R6
   pfx_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pfx_hit_i |=> !chan_load_o);

   // R7
   special_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_load_o |-> ($past(mode_q) == MODE_NORMAL));

endmodule

// File: rtl/mseq_bright_reg.sv
module mseq_bright_reg #(
   parameter int                CODE_W     = 8,
   parameter logic [CODE_W-1:0] RESET_CODE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [CODE_W-1:0] d_i,
   output logic [CODE_W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= RESET_CODE;
      end else if (we_i) begin
         q_o <= d_i;
      end
   end

   // R7
   bright_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(we_i) |-> $stable(q_o));

endmodule

// File: rtl/mseq_gain_map.sv
module mseq_gain_map #(
   parameter int CODE_W   = 8,
   parameter bit GAIN_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_i,
   output logic [CODE_W-2:0] idx_o,
   output logic [CODE_W-1:0] frac_o
);
   localparam int STEP_W = CODE_W - 2;
   localparam int IDX_W  = STEP_W + 1;
   localparam int FRAC_W = STEP_W + 2;
   localparam logic [FRAC_W-1:0] LO_BASE = FRAC_W'(1) << STEP_W;
   localparam logic [FRAC_W-1:0] HI_BASE = FRAC_W'(2) << STEP_W;

   generate
      if (CODE_W < 3) begin : g_w_bad
         $error("mseq_gain_map: CODE_W must be at least 3");
      end
   endgenerate

   logic [STEP_W-1:0] step;
   logic [IDX_W-1:0]  idx_c;
   logic [FRAC_W-1:0] frac_c;

   // step MSB sits at code bit 2, LSB at the top code bit
   generate
      for (genvar i = 0; i < STEP_W; i++) begin : g_rev
         assign step[STEP_W-1-i] = code_i[2+i];
      end
   endgenerate

   always_comb begin
      idx_c = {code_i[1], step};
      if (code_i[1]) begin
         frac_c = HI_BASE + {step, 1'b0};
      end else begin
         frac_c = LO_BASE + FRAC_W'(step);
      end
   end

   generate
      if (GAIN_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idx_o  <= '1;
               frac_o <= HI_BASE + {{STEP_W{1'b1}}, 1'b0};
            end else begin
               idx_o  <= idx_c;
               frac_o <= frac_c;
            end
         end
      end else begin : g_comb
         assign idx_o  = idx_c;
         assign frac_o = frac_c;
      end
   endgenerate

   // R9
   frac_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frac_o >= LO_BASE);

   // R9
   frac_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_o > $past(idx_o)) |-> (frac_o > $past(frac_o)));

endmodule

// File: rtl/led_mode_seq.sv
module led_mode_seq
   import mseq_pkg::*;
#(
   parameter int CODE_W   = 8,
   parameter int SEQ_LEN  = SEQ_LEN_DEF,
   parameter int PFX_LEN  = 4,
   parameter bit GAIN_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blank_i,
   input  logic              strobe_i,
   input  logic [CODE_W-1:0] sr_word_i,
   output logic              special_o,
   output logic [CODE_W-1:0] bright_o,
   output logic [CODE_W-2:0] gain_idx_o,
   output logic [CODE_W-1:0] gain_frac_o,
   output logic              chan_load_o,
   output logic              chan_clear_o
);
   generate
      if (SEQ_LEN != SEQ_LEN_DEF) begin : g_seq_bad
         $error("led_mode_seq: control patterns are defined for five steps");
      end
   endgenerate

   logic       enter_hit;
   logic       exit_hit;
   logic       pfx_hit;
   logic       bright_we;
   mseq_mode_e mode;

   mseq_history #(
      .SEQ_LEN      (SEQ_LEN),
      .PFX_LEN      (PFX_LEN),
      .ENTER_BLANK  (ENTER_BLANK_DEF),
      .ENTER_STROBE (ENTER_STROBE_DEF),
      .EXIT_BLANK   (EXIT_BLANK_DEF),
      .EXIT_STROBE  (EXIT_STROBE_DEF)
   ) u_hist (
      .clk         (clk),
      .rst_n       (rst_n),
      .blank_i     (blank_i),
      .strobe_i    (strobe_i),
      .enter_hit_o (enter_hit),
      .exit_hit_o  (exit_hit),
      .pfx_hit_o   (pfx_hit)
   );

   mseq_mode_ctl u_ctl (
      .clk          (clk),
      .rst_n        (rst_n),
      .strobe_i     (strobe_i),
      .enter_hit_i  (enter_hit),
      .exit_hit_i   (exit_hit),
      .pfx_hit_i    (pfx_hit),
      .mode_o       (mode),
      .bright_we_o  (bright_we),
      .chan_load_o  (chan_load_o),
      .chan_clear_o (chan_clear_o)
   );

   mseq_bright_reg #(
      .CODE_W     (CODE_W),
      .RESET_CODE ({CODE_W{1'b1}})
   ) u_bright (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (bright_we),
      .d_i   (sr_word_i),
      .q_o   (bright_o)
   );

   mseq_gain_map #(
      .CODE_W   (CODE_W),
      .GAIN_REG (GAIN_REG)
   ) u_gain (
      .clk    (clk),
      .rst_n  (rst_n),
      .code_i (bright_o),
      .idx_o  (gain_idx_o),
      .frac_o (gain_frac_o)
   );

   assign special_o = (mode == MODE_SPECIAL);

   // R5
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({chan_load_o, chan_clear_o, $past(bright_we)}));

endmodule

// File: tb/led_mode_seq_bench.sv
module led_mode_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       blank;
   logic       strb;
   logic [7:0] word;
   logic       special;
   logic [7:0] bright;
   logic [6:0] gidx;
   logic [7:0] gfrac;
   logic       cload;
   logic       cclr;

   int checks = 0;
   int fails  = 0;

   logic       m_special;
   logic [7:0] m_bright;
   logic [3:0] m_hb;
   logic [3:0] m_hs;
   logic       m_load;
   logic       m_clr;

   always #10 clk = ~clk;

   led_mode_seq u_led_mode_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .blank_i      (blank),
      .strobe_i     (strb),
      .sr_word_i    (word),
      .special_o    (special),
      .bright_o     (bright),
      .gain_idx_o   (gidx),
      .gain_frac_o  (gfrac),
      .chan_load_o  (cload),
      .chan_clear_o (cclr)
   );

   function automatic logic [6:0] f_idx(logic [7:0] c);
      return {c[1], c[2], c[3], c[4], c[5], c[6], c[7]};
   endfunction

   function automatic logic [7:0] f_frac(logic [7:0] c);
      logic [6:0] ix;
      ix = f_idx(c);
      if (c[1]) return 8'd128 + {1'b0, ix[5:0], 1'b0};
      return 8'd64 + {2'b00, ix[5:0]};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R2/R3 mode", {31'd0, special}, {31'd0, m_special});
      chk("R7 brightness", {24'd0, bright}, {24'd0, m_bright});
      chk("R8 gain index", {25'd0, gidx}, {25'd0, f_idx(m_bright)});
      chk("R9 gain fraction", {24'd0, gfrac}, {24'd0, f_frac(m_bright)});
      chk("R5 channel load", {31'd0, cload}, {31'd0, m_load});
      chk("R3 channel clear", {31'd0, cclr}, {31'd0, m_clr});
   endtask

   // one clock: drive now (at a falling edge), update model at rise, compare mid-high
   task automatic cyc(logic b, logic s, logic [7:0] w);
      logic [4:0] wb;
      logic [4:0] ws;
      logic       ent;
      logic       ext;
      logic       pfx;
      blank = b;
      strb  = s;
      word  = w;
      @(posedge clk);
      wb  = {m_hb, b};
      ws  = {m_hs, s};
      ent = (wb == 5'b10111) && (ws == 5'b00010);
      ext = (wb == 5'b10111) && (ws == 5'b00000);
      pfx = s && (wb[3:0] == 4'b1011) && (ws[3:0] == 4'b0001);
      m_load = s && !m_special && !pfx;
      if (s && m_special && !pfx) m_bright = w;
      m_clr = ext && m_special;
      if (ent) m_special = 1'b1;
      else if (ext) m_special = 1'b0;
      m_hb = wb[3:0];
      m_hs = ws[3:0];
      #5;
      compare_all();
      @(negedge clk);
   endtask

   task automatic enter_seq();
      cyc(1, 0, 8'h00); cyc(0, 0, 8'h00); cyc(1, 0, 8'h00);
      cyc(1, 1, 8'h5A); cyc(1, 0, 8'h00);
   endtask

   task automatic exit_seq();
      cyc(1, 0, 8'h00); cyc(0, 0, 8'h00); cyc(1, 0, 8'h00);
      cyc(1, 0, 8'h00); cyc(1, 0, 8'h00);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(1, 0, 8'h00);
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] saved;
      void'($urandom(32'd4711));
      m_special = 0; m_bright = 8'hFF; m_hb = 0; m_hs = 0; m_load = 0; m_clr = 0;
      rst_n = 0; blank = 1; strb = 1; word = 8'h00;
      repeat (3) @(posedge clk);
      #5;
      // R1 reset state
      chk("R1 mode", {31'd0, special}, 0);
      chk("R1 brightness", {24'd0, bright}, 32'hFF);
      chk("R1 load", {31'd0, cload}, 0);
      chk("R1 clear", {31'd0, cclr}, 0);
      @(negedge clk);
      rst_n = 1;
      strb  = 0;
      cyc(1, 0, 8'h00);
      chk("R1 after release", {23'd0, special, bright}, {23'd0, 1'b0, 8'hFF});

      // R5 normal latch pulses
      cyc(0, 1, 8'h12); cyc(0, 0, 8'h00); cyc(1, 1, 8'h34);
      chk("R5 bright held in normal", {24'd0, bright}, 32'hFF);

      // R3 exit while already normal: no clear
      exit_seq();
      chk("R3 no clear from normal", {31'd0, cclr}, 0);

      // R2 entry; its latch pulse must not load (R6)
      enter_seq();
      chk("R2 special entered", {31'd0, special}, 1);
      chk("R6 entry pulse kept out of brightness", {24'd0, bright}, 32'hFF);

      // R7 load in special, R8 reserved bit has no effect
      cyc(0, 1, 8'b1010_0110);
      saved = gidx;
      cyc(0, 1, 8'b1010_0111);
      chk("R8 reserved bit ignored", {25'd0, gidx}, {25'd0, saved});
      chk("R7 no channel load in special", {31'd0, cload}, 0);

      // R9 sweep all codes through the register
      for (int c = 0; c < 256; c++) begin
         cyc(0, 1, 8'(c));
         cyc(0, 0, 8'h00);
      end

      // R6 lone prefix in special: pulse suppressed
      saved = bright;
      cyc(1, 0, 8'h00); cyc(0, 0, 8'h00); cyc(1, 0, 8'h00); cyc(1, 1, 8'h3C);
      chk("R6 prefix pulse suppressed", {24'd0, bright}, {24'd0, saved});
      cyc(0, 0, 8'h00);
      chk("R4 broken entry keeps special", {31'd0, special}, 1);

      // R3 exit from special with clear
      exit_seq();
      chk("R3 back to normal", {31'd0, special}, 0);
      chk("R3 clear pulse", {31'd0, cclr}, 1);
      cyc(1, 0, 8'h00);
      chk("R3 clear one cycle", {31'd0, cclr}, 0);

      // R4 single-sample deviations of entry pattern
      for (int k = 0; k < 10; k++) begin
         logic [4:0] pb;
         logic [4:0] ps;
         pb = 5'b10111; ps = 5'b00010;
         if (k < 5) pb[k] = ~pb[k]; else ps[k-5] = ~ps[k-5];
         idle(2);
         for (int j = 4; j >= 0; j--) cyc(pb[j], ps[j], 8'h77);
         chk("R4 deviated entry", {31'd0, special}, 0);
      end

      // R6 lone prefix in normal: no channel load
      idle(2);
      cyc(1, 0, 8'h00); cyc(0, 0, 8'h00); cyc(1, 0, 8'h00); cyc(1, 1, 8'h00);
      chk("R6 prefix no channel load", {31'd0, cload}, 0);

      // random traffic, toggling modes
      for (int r = 0; r < 6; r++) begin
         for (int i = 0; i < 400; i++)
            cyc(1'($urandom), 1'($urandom_range(0, 3) == 0), 8'($urandom));
         idle(1);
         if (r % 2 == 0) enter_seq(); else exit_seq();
      end
      exit_seq();
      chk("R3 final normal", {31'd0, special}, 0);
      finish_run();
   end
endmodule